// File: doc/BRIEF.md
# Dual-clock FIFO with programmable status flags

This block passes data words from a write clock domain to a read clock domain through a storage array of 2^ADDR_W words. Each domain keeps its own binary and Gray-coded pointer. The Gray pointer crosses into the other domain through a register chain, and each direction has its own length parameter. The write side raises `full_o` and `afull_o` by comparing its own pointer with the synchronized read pointer. The read side raises `empty_o` and `aempty_o` by comparing its own pointer with the synchronized write pointer. Because every copied pointer is late, the flags are conservative: the write side can report too little free space but never too much, and the read side can report too few stored words but never too many.

The read port works in first-word-fall-through style: whenever `empty_o` is low, `rd_data_o` shows the oldest stored word, and a read moves on to the next one. A write attempted while full, or a read attempted while empty, leaves the pointers and the stored words untouched, and it raises a one-cycle error flag in the next cycle of that domain. The almost-full threshold tells the writer how many words it may write blind. When `afull_o` is low, at least AF_OFFSET+1 entries are free. When `SYNC_MODE` is 1, both clocks must be the same clock; the chains are then removed and each side compares against the raw pointer of the other side.

Top module: `dual_clock_fifo`

## Requirements
- R1: While `rst_ni` is low, and asynchronously from the moment it falls, `empty_o` and `aempty_o` are 1 and `full_o`, `afull_o`, `wr_err_o` and `rd_err_o` are 0. The release is synchronized separately to each clock, and the FIFO restarts empty.
- R2: Words leave in the order they were accepted. While `empty_o` is 0, `rd_data_o` equals the oldest unread accepted word.
- R3: `full_o` is 1 exactly when the write pointer minus the synchronized read pointer equals 2^ADDR_W. A write while `full_o` is 1 is discarded.
- R4: `empty_o` is 1 exactly when the synchronized write pointer equals the read pointer. A read while `empty_o` is 1 is discarded.
- R5: `afull_o` is 1 when the write-side word count is at least 2^ADDR_W − AF_OFFSET, where AF_OFFSET is a 7-bit parameter. While `afull_o` is 0, at least AF_OFFSET+1 entries are actually free.
- R6: `aempty_o` is 1 when the read-side word count is at most AE_OFFSET.
- R7: `wr_err_o` is 1 in the `wclk_i` cycle that follows a write attempt made while `full_o` was 1, and 0 in every other cycle.
- R8: `rd_err_o` is 1 in the `rclk_i` cycle that follows a read attempt made while `empty_o` was 1, and 0 in every other cycle.
- R9: With `SYNC_MODE` = 0, a read becomes visible in the write-side flags RD2WR_STAGES `wclk_i` edges after the edge that took it. A write becomes visible in the read-side flags WR2RD_STAGES `rclk_i` edges after the edge that took it.
- R10: With `SYNC_MODE` = 1, both clocks are one clock. The flags of each side react to the other side's pointer update without added delay.
- R11: Both Gray pointers change by at most one bit per clock edge of their own domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-domain clock |
| rclk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset shared by both domains |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to store |
| full_o | output | 1 | No free entry (write domain) |
| afull_o | output | 1 | Free entries at or below AF_OFFSET (write domain) |
| wr_err_o | output | 1 | Previous-cycle write was refused |
| rd_en_i | input | 1 | Read request, advances to the next word |
| rd_data_o | output | DATA_W | Oldest stored word, valid while empty_o is 0 |
| empty_o | output | 1 | No visible word (read domain) |
| aempty_o | output | 1 | Visible words at or below AE_OFFSET (read domain) |
| rd_err_o | output | 1 | Previous-cycle read was refused |

## Verification
The status flags are combinational functions of registered pointers. They therefore change right after the clock edge that moves the local pointer, while the remote pointer reaches them only after the stage count of its chain (R9), or with no delay in bypass mode (R10). The error flags follow the refused request by exactly one edge. The bench keeps per-edge histories of the accepted write and read counts and rebuilds each flag from the entry that lies the chain length back. It compares the flags on the falling edge that follows each rising edge, so every registered result has settled. The bench drives two instances, one with synchronizer chains and one in bypass mode, from the same clock, which makes the crossing latency exact and checkable.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic {
    PTR_SYNC_CHAIN  = 1'b0,
    PTR_SYNC_BYPASS = 1'b1
  } ptr_mode_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= 2'b00;
    else         stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_no = stg_q[1];
endmodule

// File: rtl/dcf_ptr_sync.sv
module dcf_ptr_sync #(
  parameter int unsigned PW     = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] d_i,
  output logic [PW-1:0] q_o
);
  localparam int unsigned NST = (STAGES < 1) ? 1 : STAGES;

  logic [PW-1:0] st_q [NST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NST); i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < int'(NST); i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[NST-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_side.sv
module dcf_wr_side #(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [6:0]  AF_OFFSET = 7'd4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W:0]   rgray_i,
  output logic [ADDR_W:0]   wgray_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic              wr_ok_o,
  output logic              full_o,
  output logic              afull_o,
  output logic              wr_err_o
);
  localparam int unsigned PW       = ADDR_W + 1;
  localparam int unsigned DEPTH    = 1 << ADDR_W;
  localparam logic [PW-1:0] AF_LVL = PW'(DEPTH - 32'(AF_OFFSET));

  logic [PW-1:0] wbin_q, wbin_nxt, wgray_q, rbin_s, used;
  logic          err_q;

  assign rbin_s  = PW'(dcf_pkg::gray2bin(32'(rgray_i)));
  assign used    = wbin_q - rbin_s;
  assign full_o  = (wgray_q == {~rgray_i[PW-1:PW-2], rgray_i[PW-3:0]});
  assign afull_o = (used >= AF_LVL);
  assign wr_ok_o = wr_en_i & ~full_o;
  assign wbin_nxt = wbin_q + PW'(wr_ok_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      err_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= PW'(dcf_pkg::bin2gray(32'(wbin_nxt)));
      err_q   <= wr_en_i & full_o;
    end
  end

  assign wgray_o  = wgray_q;
  assign waddr_o  = wbin_q[ADDR_W-1:0];
  assign wr_err_o = err_q;

  a_r3_hold_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> $stable(wbin_q));
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used <= PW'(DEPTH));
  a_r7_err_after_refusal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o) |=> wr_err_o);
  a_r7_err_only_after_refusal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(wr_en_i && full_o));
  a_r11_wgray_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
endmodule

// File: rtl/dcf_rd_side.sv
module dcf_rd_side #(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [6:0]  AE_OFFSET = 7'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W:0]   wgray_i,
  output logic [ADDR_W:0]   rgray_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              rd_err_o
);
  localparam int unsigned PW    = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PW-1:0] rbin_q, rbin_nxt, rgray_q, wbin_s, avail;
  logic          rd_ok, err_q;

  assign wbin_s   = PW'(dcf_pkg::gray2bin(32'(wgray_i)));
  assign avail    = wbin_s - rbin_q;
  assign empty_o  = (rgray_q == wgray_i);
  assign aempty_o = (32'(avail) <= 32'(AE_OFFSET));
  assign rd_ok    = rd_en_i & ~empty_o;
  assign rbin_nxt = rbin_q + PW'(rd_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= PW'(dcf_pkg::bin2gray(32'(rbin_nxt)));
      err_q   <= rd_en_i & empty_o;
    end
  end

  assign rgray_o  = rgray_q;
  assign raddr_o  = rbin_q[ADDR_W-1:0];
  assign rd_err_o = err_q;

  a_r4_hold_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o) |=> $stable(rbin_q));
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    avail <= PW'(DEPTH));
  a_r8_err_after_refusal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && empty_o) |=> rd_err_o);
  a_r8_err_only_after_refusal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> $past(rd_en_i && empty_o));
  a_r11_rgray_one_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int unsigned       DATA_W       = 8,
  parameter int unsigned       ADDR_W       = 4,
  parameter logic [6:0]        AF_OFFSET    = 7'd4,
  parameter logic [6:0]        AE_OFFSET    = 7'd2,
  parameter int unsigned       WR2RD_STAGES = 2,
  parameter int unsigned       RD2WR_STAGES = 3,
  parameter dcf_pkg::ptr_mode_e SYNC_MODE   = dcf_pkg::PTR_SYNC_CHAIN
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  output logic              afull_o,
  output logic              wr_err_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              rd_err_o
);
  localparam int unsigned PW = ADDR_W + 1;

  logic              wrst_n, rrst_n, wr_ok;
  logic [PW-1:0]     wgray, rgray, wgray_at_r, rgray_at_w;
  logic [ADDR_W-1:0] waddr, raddr;

  dcf_rst_sync i_wrst (.clk_i(wclk_i), .rst_ni(rst_ni), .rst_no(wrst_n));
  dcf_rst_sync i_rrst (.clk_i(rclk_i), .rst_ni(rst_ni), .rst_no(rrst_n));

  generate
    if (SYNC_MODE == dcf_pkg::PTR_SYNC_BYPASS) begin : g_bypass
      assign wgray_at_r = wgray;
      assign rgray_at_w = rgray;
    end else begin : g_chain
      dcf_ptr_sync #(.PW(PW), .STAGES(WR2RD_STAGES)) i_w2r (
        .clk_i(rclk_i), .rst_ni(rrst_n), .d_i(wgray), .q_o(wgray_at_r));
      dcf_ptr_sync #(.PW(PW), .STAGES(RD2WR_STAGES)) i_r2w (
        .clk_i(wclk_i), .rst_ni(wrst_n), .d_i(rgray), .q_o(rgray_at_w));
    end
  endgenerate

  dcf_wr_side #(.ADDR_W(ADDR_W), .AF_OFFSET(AF_OFFSET)) i_wr (
    .clk_i(wclk_i), .rst_ni(wrst_n), .wr_en_i(wr_en_i), .rgray_i(rgray_at_w),
    .wgray_o(wgray), .waddr_o(waddr), .wr_ok_o(wr_ok), .full_o(full_o),
    .afull_o(afull_o), .wr_err_o(wr_err_o));

  dcf_rd_side #(.ADDR_W(ADDR_W), .AE_OFFSET(AE_OFFSET)) i_rd (
    .clk_i(rclk_i), .rst_ni(rrst_n), .rd_en_i(rd_en_i), .wgray_i(wgray_at_r),
    .rgray_o(rgray), .raddr_o(raddr), .empty_o(empty_o), .aempty_o(aempty_o),
    .rd_err_o(rd_err_o));

  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
    .clk_i(wclk_i), .we_i(wr_ok), .waddr_i(waddr), .wdata_i(wr_data_i),
    .raddr_i(raddr), .rdata_o(rd_data_o));

  a_r1_reset_flags: assert property (@(posedge wclk_i)
    !rst_ni |-> (!full_o && !afull_o && !wr_err_o));
endmodule

// File: tb/test_dual_clock_fifo.sv
module test_dual_clock_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int AF = 4;
  localparam int AE = 2;
  localparam int W2R = 2;
  localparam int R2W = 3;
  localparam int MAXC = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wd [2];
  logic [7:0] rdat [2];
  logic full [2], afull [2], werr [2], empty [2], aempty [2], rerr [2];

  int wh [2][0:MAXC];
  int rh [2][0:MAXC];
  int lag_w2r [2] = '{W2R, 0};
  int lag_r2w [2] = '{R2W, 0};
  bit exp_werr [2], exp_rerr [2];
  int k = 0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_clock_fifo #(.DATA_W(8), .ADDR_W(4), .AF_OFFSET(7'd4), .AE_OFFSET(7'd2),
    .WR2RD_STAGES(W2R), .RD2WR_STAGES(R2W), .SYNC_MODE(dcf_pkg::PTR_SYNC_CHAIN)) i_dual_clock_fifo (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wd[0]),
    .full_o(full[0]), .afull_o(afull[0]), .wr_err_o(werr[0]), .rd_en_i(rd_en),
    .rd_data_o(rdat[0]), .empty_o(empty[0]), .aempty_o(aempty[0]), .rd_err_o(rerr[0]));

  dual_clock_fifo #(.DATA_W(8), .ADDR_W(4), .AF_OFFSET(7'd4), .AE_OFFSET(7'd2),
    .WR2RD_STAGES(W2R), .RD2WR_STAGES(R2W), .SYNC_MODE(dcf_pkg::PTR_SYNC_BYPASS)) i_dual_clock_fifo_bp (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wd[1]),
    .full_o(full[1]), .afull_o(afull[1]), .wr_err_o(werr[1]), .rd_en_i(rd_en),
    .rd_data_o(rdat[1]), .empty_o(empty[1]), .aempty_o(aempty[1]), .rd_err_o(rerr[1]));

  function automatic logic [7:0] word_of(int n);
    return 8'((n * 29 + 3) % 256);
  endfunction

  function automatic int hw(int i, int j);
    return (j < 0) ? 0 : wh[i][j];
  endfunction

  function automatic int hr(int i, int j);
    return (j < 0) ? 0 : rh[i][j];
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (edge %0d)", req, what, act, exp, k);
    end
  endtask

  // R9 applies to instance 0 (chains), R10 to instance 1 (bypass)
  task automatic compare();
    for (int i = 0; i < 2; i++) begin
      string lat = (i == 0) ? "R9" : "R10";
      int occ_w = wh[i][k] - hr(i, k - lag_r2w[i]);
      int occ_r = hw(i, k - lag_w2r[i]) - rh[i][k];
      bit e_full = (occ_w == DEPTH);
      bit e_afull = (occ_w >= DEPTH - AF);
      bit e_empty = (occ_r == 0);
      bit e_aempty = (occ_r <= AE);
      chk(full[i] == e_full, {"R3/", lat}, "full", int'(full[i]), int'(e_full));
      chk(afull[i] == e_afull, {"R5/", lat}, "afull", int'(afull[i]), int'(e_afull));
      chk(empty[i] == e_empty, {"R4/", lat}, "empty", int'(empty[i]), int'(e_empty));
      chk(aempty[i] == e_aempty, {"R6/", lat}, "aempty", int'(aempty[i]), int'(e_aempty));
      chk(werr[i] == exp_werr[i], "R7", "wr_err", int'(werr[i]), int'(exp_werr[i]));
      chk(rerr[i] == exp_rerr[i], "R8", "rd_err", int'(rerr[i]), int'(exp_rerr[i]));
      if (!e_empty)
        chk(rdat[i] == word_of(rh[i][k]), "R2", "rd_data", int'(rdat[i]), int'(word_of(rh[i][k])));
      if (!afull[i])  // R5 blind-write guarantee against the true count
        chk(DEPTH - (wh[i][k] - rh[i][k]) >= AF + 1, "R5", "free entries",
            DEPTH - (wh[i][k] - rh[i][k]), AF + 1);
    end
  endtask

  task automatic step(bit we, bit re);
    if (k >= MAXC) return;
    wr_en = we;
    rd_en = re;
    for (int i = 0; i < 2; i++) begin
      int occ_w = wh[i][k] - hr(i, k - lag_r2w[i]);
      int occ_r = hw(i, k - lag_w2r[i]) - rh[i][k];
      bit f = (occ_w == DEPTH);
      bit e = (occ_r == 0);
      wd[i] = word_of(wh[i][k]);
      exp_werr[i] = we && f;
      exp_rerr[i] = re && e;
      wh[i][k+1] = wh[i][k] + ((we && !f) ? 1 : 0);
      rh[i][k+1] = rh[i][k] + ((re && !e) ? 1 : 0);
    end
    @(posedge clk);
    k++;
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset();
    wr_en = 1'b0;
    rd_en = 1'b0;
    rst_n = 1'b0;
    #1;
    // R1: reset acts at once, without waiting for an edge
    for (int i = 0; i < 2; i++) begin
      chk(empty[i] == 1'b1 && aempty[i] == 1'b1, "R1", "empty/aempty in reset",
          int'({empty[i], aempty[i]}), 3);
      chk(full[i] == 1'b0 && afull[i] == 1'b0 && werr[i] == 1'b0 && rerr[i] == 1'b0,
          "R1", "full/afull/errors in reset", int'({full[i], afull[i], werr[i], rerr[i]}), 0);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    k = 0;
    for (int i = 0; i < 2; i++) begin
      wh[i][0] = 0;
      rh[i][0] = 0;
      exp_werr[i] = 1'b0;
      exp_rerr[i] = 1'b0;
    end
    compare();  // R1: FIFO restarts empty
  endtask

  task automatic random_run(int n, int pw, int pr);
    for (int c = 0; c < n; c++)
      step($urandom_range(99, 0) < pw, $urandom_range(99, 0) < pr);
  endtask

  initial begin
    wd[0] = '0;
    wd[1] = '0;
    @(negedge clk);
    do_reset();
    // fill past full: R3 refusals and R7 errors
    for (int c = 0; c < 24; c++) step(1'b1, 1'b0);
    // drain past empty: R4 refusals and R8 errors
    for (int c = 0; c < 24; c++) step(1'b0, 1'b1);
    // single write then immediate read: R9 latency of the crossing
    step(1'b1, 1'b0);
    for (int c = 0; c < 4; c++) step(1'b0, 1'b1);
    // simultaneous read and write while full
    for (int c = 0; c < 20; c++) step(1'b1, 1'b0);
    for (int c = 0; c < 10; c++) step(1'b1, 1'b1);
    random_run(600, 70, 40);
    random_run(600, 40, 70);
    random_run(600, 55, 55);
    // R1: reset arriving with data held
    for (int c = 0; c < 8; c++) step(1'b1, 1'b0);
    do_reset();
    random_run(600, 60, 50);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule